// File: doc/BRIEF.md
# Gray-Coded Position Domain Crossing

This block moves a multi-bit position count from an asynchronous source clock domain into a sampling clock domain. A reading taken while the count changes is never torn or scrambled. On the source side an up/down counter advances by single steps and is re-encoded as Gray code into a register. Only one bit of that register toggles per step.

The sampling side passes the registered Gray word through a chain of capture registers on its own clock. The default chain has two registers. The sampling side then decodes the word back to binary and registers the result. A one-cycle strobe marks each new value. A sample taken mid-change can catch only the single toggling bit in doubt, so the result is either the old count or the new one and never an unrelated value.

The scheme depends on the sampling clock running faster than the position changes, so that at most one bit toggles between samples.

Top module: `gray_pos_xfer`

## Requirements
- R1: Each step changes exactly one bit of `src_gray_o`. When no step occurs, `src_gray_o` does not change.
- R2: `src_gray_o` equals `cnt ^ (cnt >> 1)`, where `cnt` is the binary source count. For the three low bits this gives counts 0..7 as 000, 001, 011, 010, 110, 111, 101, 100.
- R3: On a `src_clk_i` edge with `step_i` high, the count moves by one. It moves up when `dir_up_i` is 1 and down when `dir_up_i` is 0. The new Gray word is visible after that same edge.
- R4: The count wraps in both directions. Stepping up from 2^POS_W-1 gives 0, and stepping down from 0 gives 2^POS_W-1.
- R5: Every source count reaches `pos_o` in binary, in order and exactly once. Each source step yields one new `pos_o` value, and each new value differs from the previous `pos_o` by exactly one, modulo 2^POS_W.
- R6: `valid_o` is high for exactly one `smp_clk_i` cycle each time `pos_o` takes a new value. While `valid_o` is low, `pos_o` holds.
- R7: While `rst_ni` is low, `src_gray_o`, `pos_o` and `valid_o` are all zero.
- R8: The step between 0x0FF and 0x100, in either direction, shows up at `pos_o` as a single change with a single strobe and no intermediate value.
- R9: With `step_i` low, the count holds and no `valid_o` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source-domain clock |
| smp_clk_i | input | 1 | Sampling-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| step_i | input | 1 | Move the count by one on this source edge |
| dir_up_i | input | 1 | Step direction: 1 up, 0 down |
| src_gray_o | output | POS_W | Registered Gray form of the source count |
| pos_o | output | POS_W | Binary position in the sampling domain |
| valid_o | output | 1 | One-cycle strobe on each new `pos_o` value |

## Verification
The counter is driven through four patterns:
- short upward runs;
- a downward run through zero, which tells the low wrap apart from an ordinary decrement;
- an upward run through the top code, which checks the high wrap;
- runs in both directions across 0x0FF/0x100, where plain binary capture would risk a reading unrelated to either count.

The sequence of strobed outputs is compared in order against the sequence of source counts, so a lost, repeated or extra update is caught, as is a wrong decode. An idle stretch with `step_i` low confirms that nothing moves and no strobe fires.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;
  localparam int unsigned POS_W_DEF      = 10;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/gpx_bin2gray.sv
`timescale 1ns/1ps
module gpx_bin2gray #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  assign gray_o[W-1] = bin_i[W-1];
  for (genvar i = 0; i < W-1; i++) begin : g_bit
    assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
  end
endmodule

// File: rtl/gpx_gray2bin.sv
`timescale 1ns/1ps
module gpx_gray2bin #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  // each binary bit folds every Gray bit from the top down to it
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/gpx_src_counter.sv
`timescale 1ns/1ps
module gpx_src_counter
  import gpx_pkg::*;
#(
  parameter int unsigned W = POS_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         dir_up_i,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] cnt_q, cnt_d, gray_d, gray_q;
  dir_e         dir;

  assign dir = dir_e'(dir_up_i);

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) cnt_d = (dir == DIR_UP) ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  gpx_bin2gray #(.W(W)) u_b2g (.bin_i(cnt_d), .gray_o(gray_d));

  // Gray word leaves from a flop: no decode glitches cross
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/gpx_sync.sv
`timescale 1ns/1ps
module gpx_sync
  import gpx_pkg::*;
#(
  parameter int unsigned W     = POS_W_DEF,
  parameter int unsigned DEPTH = SYNC_DEPTH_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/gray_pos_xfer.sv
`timescale 1ns/1ps
module gray_pos_xfer
  import gpx_pkg::*;
#(
  parameter int unsigned POS_W      = POS_W_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic             src_clk_i,
  input  logic             smp_clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_up_i,
  output logic [POS_W-1:0] src_gray_o,
  output logic [POS_W-1:0] pos_o,
  output logic             valid_o
);
  logic [POS_W-1:0] gray_src, gray_smp, bin_smp, pos_q;
  logic             valid_q;

  gpx_src_counter #(.W(POS_W)) u_src (
    .clk_i    (src_clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .dir_up_i (dir_up_i),
    .gray_o   (gray_src)
  );

  gpx_sync #(.W(POS_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (smp_clk_i),
    .rst_ni (rst_ni),
    .d_i    (gray_src),
    .q_o    (gray_smp)
  );

  gpx_gray2bin #(.W(POS_W)) u_g2b (.gray_i(gray_smp), .bin_o(bin_smp));

  always_ff @(posedge smp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      pos_q   <= bin_smp;
      valid_q <= (bin_smp != pos_q);
    end
  end

  assign src_gray_o = gray_src;
  assign pos_o      = pos_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/gpx_checker.sv
`timescale 1ns/1ps
module gpx_checker #(
  parameter int unsigned W = 10
) (
  input logic         src_clk_i,
  input logic         smp_clk_i,
  input logic         rst_ni,
  input logic         step_i,
  input logic [W-1:0] src_gray_o,
  input logic [W-1:0] pos_o,
  input logic         valid_o
);
  p_gray_single_bit_r1: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (src_gray_o != $past(src_gray_o)) |-> ($countones(src_gray_o ^ $past(src_gray_o)) == 1));

  p_step_moves_r3: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    step_i |=> (src_gray_o != $past(src_gray_o)));

  p_idle_holds_r9: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(src_gray_o));

  p_unit_move_r5: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    valid_o |-> ((W'(pos_o - $past(pos_o)) == W'(1)) || (W'($past(pos_o) - pos_o) == W'(1))));

  p_strobe_on_change_r6: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    valid_o |-> (pos_o != $past(pos_o)));

  p_quiet_holds_r6: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pos_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_zero_r7: assert (pos_o == '0 && !valid_o);
    end
  end
endmodule

bind gray_pos_xfer gpx_checker #(.W(POS_W)) u_chk (
  .src_clk_i  (src_clk_i),
  .smp_clk_i  (smp_clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_i),
  .src_gray_o (src_gray_o),
  .pos_o      (pos_o),
  .valid_o    (valid_o)
);

// File: tb/gray_pos_xfer_tb.sv
`timescale 1ns/1ps
module gray_pos_xfer_tb;
  localparam int unsigned W = 10;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic src_clk = 1'b0, smp_clk = 1'b0, rst_n = 1'b0;
  logic step = 1'b0, dir_up = 1'b1;
  logic [W-1:0] gray, pos;
  logic valid;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q [$];
  int n_valid = 0;

  always #4    smp_clk = ~smp_clk;   // 125 MHz
  always #18.5 src_clk = ~src_clk;   // slower, unrelated

  gray_pos_xfer #(.POS_W(W)) u_dut (
    .src_clk_i (src_clk),
    .smp_clk_i (smp_clk),
    .rst_ni    (rst_n),
    .step_i    (step),
    .dir_up_i  (dir_up),
    .src_gray_o(gray),
    .pos_o     (pos),
    .valid_o   (valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // driver: steps the source and queues each expected count
  task automatic run(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] prev_gray;
      @(negedge src_clk);
      prev_gray = gray;
      step   = 1'b1;
      dir_up = up;
      @(posedge src_clk);
      model = up ? model + W'(1) : model - W'(1);
      exp_q.push_back(model);
      #2;
      chk("R2 gray encoding", 32'(gray), 32'(model ^ (model >> 1)));
      chk("R1 single bit per step", 32'($countones(gray ^ prev_gray)), 32'd1);
    end
    @(negedge src_clk);
    step = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge smp_clk);
    chk("R5 queue drained", 32'(exp_q.size()), 32'd0);
    chk("R5 final position", 32'(pos), 32'(model));
  endtask

  // monitor: each strobe pops the next expected count
  always @(negedge smp_clk) begin
    if (rst_n && valid) begin
      n_valid++;
      if (exp_q.size() == 0) begin
        chk("R6 strobe without step", 32'd1, 32'd0);
      end else begin
        chk("R5 in-order position", 32'(pos), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge smp_clk);
    chk("R7 reset gray", 32'(gray), 32'd0);
    chk("R7 reset pos", 32'(pos), 32'd0);
    chk("R7 reset valid", 32'(valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge src_clk);

    run(5, 1'b1);                       // R3 up
    settle();
    run(7, 1'b0);                       // R4 down through zero
    settle();
    chk("R4 low wrap", 32'(model), 32'(TOP - W'(1)));
    run(3, 1'b1);                       // R4 up through top
    settle();
    chk("R4 high wrap", 32'(pos), 32'd1);

    // R9: idle stretch, nothing moves
    begin
      logic [W-1:0] g0, p0;
      int v0;
      g0 = gray; p0 = pos; v0 = n_valid;
      repeat (20) @(negedge src_clk);
      chk("R9 gray holds", 32'(gray), 32'(g0));
      chk("R9 pos holds", 32'(pos), 32'(p0));
      chk("R9 no strobe", 32'(n_valid - v0), 32'd0);
    end

    run(254, 1'b1);                     // to 0x0FF
    settle();
    chk("R8 at 0x0FF", 32'(pos), 32'h0FF);
    begin
      int v0;
      v0 = n_valid;
      run(1, 1'b1);
      settle();
      chk("R8 up to 0x100", 32'(pos), 32'h100);
      chk("R8 single strobe up", 32'(n_valid - v0), 32'd1);
      v0 = n_valid;
      run(1, 1'b0);
      settle();
      chk("R8 down to 0x0FF", 32'(pos), 32'h0FF);
      chk("R8 single strobe down", 32'(n_valid - v0), 32'd1);
    end
    run(6, 1'b1);
    run(4, 1'b0);
    settle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule